// File: doc/BRIEF.md
# Host Port Memory and Mailbox Slave

This block lets an external processor reach a word-organised internal memory and exchange single words with internal logic, all through a 16-bit parallel port. The host picks one of four registers with a two-bit select and pulses a read or a write strobe. The strobes arrive asynchronously, so the block synchronises them and acts once per strobe pulse. A host access lasts at least 125 ns, which is about 31 cycles of the internal clock. The block finishes every access well inside that window.

The host first writes a byte address into the pointer register. It can then stream through memory with repeated data-port accesses, and the pointer steps by one word after each of them. Two single-word mailboxes carry traffic in each direction. A word posted by the internal side raises a flag, and that flag drives the host interrupt. When the host reads the mailbox, it gets the word and the flag clears, which acknowledges the message. A word written by the host is held with a valid flag until the internal side takes it.

The memory request port and both mailbox ports use valid/ready handshakes. The memory request (`mem_valid`) keeps its address, direction and data unchanged while `mem_ready` is low. Read data returns on `mem_rvalid` exactly one cycle after the request is accepted, and that return path cannot be stalled. The outgoing mailbox stalls the internal side by holding `mbo_ready` low while an earlier word is still pending. The incoming mailbox completes a transfer on any cycle in which `mbi_valid` and `mbi_ready` are both high.

Top module: `hpi_slave`

## Requirements
- R1: Reset clears the pointer, the outgoing flag (so `host_irq` is low and `mbo_ready` is high), the incoming valid flag, and the memory request.
- R2: The register select decodes as follows: 0 is the data port, 1 is the mailbox, 2 is the pointer and 3 is status.
- R3: Each strobe takes effect on the third rising clock edge after it rises. Exactly one access happens per strobe pulse, however long the strobe is held.
- R4: A pointer write loads the host word as a byte address, and a pointer read returns the pointer. Memory requests use word address `ptr[15:1]`, so bit 0 of the pointer has no effect on which word is reached.
- R5: A data-port write requests a memory write of the host word at the pointer's word address. The request is held unchanged while `mem_ready` is low, and the pointer advances by 2 when the memory accepts the request.
- R6: A data-port read requests the word at the pointer, and the pointer advances by 2 on acceptance. `host_rdata` takes the returned word on the edge at which `mem_rvalid` is high, one edge after acceptance, and it then holds until the next read completes.
- R7: The internal side can post a word only while the outgoing flag is clear (`mbo_ready` high). A completed post sets the flag, and `host_irq` follows the flag.
- R8: A status read returns the outgoing flag in bit 0 and zero in all other bits.
- R9: A host mailbox read returns the posted word and clears the outgoing flag on the same edge, so `host_irq` drops.
- R10: A host mailbox write stores the word and sets `mbi_valid`. A handshake with `mbi_ready` clears the flag. A host write while a word is still pending replaces that word. If a host write and a handshake fall on the same edge, the new word is kept and `mbi_valid` stays high.
- R11: The pointer wraps from 0xFFFE to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Host register select |
| host_rd | input | 1 | Host read strobe, asynchronous, active high |
| host_wr | input | 1 | Host write strobe, asynchronous, active high |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_irq | output | 1 | Outgoing mailbox message pending |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid, one cycle after acceptance |
| mem_rdata | input | 16 | Read data |
| mbo_valid | input | 1 | Internal side posts a word to the host |
| mbo_ready | output | 1 | Outgoing mailbox free |
| mbo_data | input | 16 | Word posted to the host |
| mbi_valid | output | 1 | Host word pending for the internal side |
| mbi_ready | input | 1 | Internal side takes the pending word |
| mbi_data | output | 16 | Host word |

## Verification
Every host access takes effect on the third rising edge after its strobe rises. A data read also waits for the memory: it completes on the edge after acceptance, so with three stall cycles the data arrives by the eighth edge. The reference model updates each flag at the falling edge that follows the edge on which the change is due, and it compares `host_irq`, `mbo_ready` and `mbi_valid` half a cycle later on every clock. Host read data is sampled fourteen cycles into each strobe, past the slowest path. Mailbox handshakes are driven at falling edges so that they land on a known rising edge, and this includes a host write that coincides with the internal read.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_MBX  = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_STAT = 2'd3
  } hpi_sel_e;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_REQ  = 2'd1,
    XF_WAIT = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/hpi_strobe_det.sv
module hpi_strobe_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic evt
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], strobe};
  end

  // one pulse per rising strobe, after STAGES synchroniser flops
  assign evt = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/hpi_mailbox.sv
module hpi_mailbox #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_take,
  input  logic          host_post,
  input  logic [DW-1:0] host_word,
  input  logic          mbo_valid,
  output logic          mbo_ready,
  input  logic [DW-1:0] mbo_data,
  output logic          out_flag,
  output logic [DW-1:0] out_word,
  output logic          mbi_valid,
  input  logic          mbi_ready,
  output logic [DW-1:0] mbi_data
);
  assign mbo_ready = ~out_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_flag <= 1'b0;
      out_word <= '0;
    end else if (mbo_valid && mbo_ready) begin
      out_flag <= 1'b1;
      out_word <= mbo_data;
    end else if (host_take) begin
      out_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbi_valid <= 1'b0;
      mbi_data  <= '0;
    end else if (host_post) begin
      mbi_valid <= 1'b1;
      mbi_data  <= host_word;
    end else if (mbi_valid && mbi_ready) begin
      mbi_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hpi_mem_xfer.sv
module hpi_mem_xfer
  import hpi_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ptr,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic [DW-1:0] host_word,
  output logic [DW-1:0] ptr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [DW-2:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  output logic          rd_done
);
  localparam logic [DW-1:0] STEP = DW'(2);

  xfer_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= XF_IDLE;
      ptr       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      unique case (st)
        XF_IDLE: begin
          if (load_ptr) begin
            ptr <= host_word;
          end else if (rd_go || wr_go) begin
            mem_we    <= wr_go;
            mem_addr  <= ptr[DW-1:1];
            mem_wdata <= host_word;
            st        <= XF_REQ;
          end
        end
        XF_REQ: begin
          if (mem_ready) begin
            ptr <= ptr + STEP;
            st  <= mem_we ? XF_IDLE : XF_WAIT;
          end
        end
        XF_WAIT: begin
          if (mem_rvalid) st <= XF_IDLE;
        end
        default: st <= XF_IDLE;
      endcase
    end
  end

  assign mem_valid = (st == XF_REQ);
  assign rd_done   = (st == XF_WAIT) && mem_rvalid;
endmodule

// File: rtl/hpi_slave.sv
module hpi_slave
  import hpi_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [DW-2:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mbo_valid,
  output logic          mbo_ready,
  input  logic [DW-1:0] mbo_data,
  output logic          mbi_valid,
  input  logic          mbi_ready,
  output logic [DW-1:0] mbi_data
);
  logic          rd_evt, wr_evt;
  logic          out_flag, rd_done;
  logic [DW-1:0] out_word, ptr;
  hpi_sel_e      sel;

  assign sel = hpi_sel_e'(host_sel);

  hpi_strobe_det #(.STAGES(SYNC_STAGES)) u_rd_det (
    .clk(clk), .rst_n(rst_n), .strobe(host_rd), .evt(rd_evt));
  hpi_strobe_det #(.STAGES(SYNC_STAGES)) u_wr_det (
    .clk(clk), .rst_n(rst_n), .strobe(host_wr), .evt(wr_evt));

  hpi_mailbox #(.DW(DW)) u_mbx (
    .clk(clk), .rst_n(rst_n),
    .host_take(rd_evt && sel == SEL_MBX),
    .host_post(wr_evt && sel == SEL_MBX),
    .host_word(host_wdata),
    .mbo_valid(mbo_valid), .mbo_ready(mbo_ready), .mbo_data(mbo_data),
    .out_flag(out_flag), .out_word(out_word),
    .mbi_valid(mbi_valid), .mbi_ready(mbi_ready), .mbi_data(mbi_data));

  hpi_mem_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .load_ptr(wr_evt && sel == SEL_PTR),
    .rd_go(rd_evt && sel == SEL_DATA),
    .wr_go(wr_evt && sel == SEL_DATA),
    .host_word(host_wdata),
    .ptr(ptr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .rd_done(rd_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (rd_done) begin
      host_rdata <= mem_rdata;
    end else if (rd_evt) begin
      unique case (sel)
        SEL_MBX:  host_rdata <= out_word;
        SEL_PTR:  host_rdata <= ptr;
        SEL_STAT: host_rdata <= {{(DW-1){1'b0}}, out_flag};
        default:  host_rdata <= host_rdata;
      endcase
    end
  end

  assign host_irq = out_flag;
endmodule

// File: rtl/hpi_slave_chk.sv
module hpi_slave_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    host_sel,
  input logic          rd_evt,
  input logic          wr_evt,
  input logic [DW-1:0] host_rdata,
  input logic          host_irq,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [DW-2:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rvalid,
  input logic          mbo_valid,
  input logic          mbo_ready,
  input logic          mbi_valid,
  input logic          mbi_ready
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt || wr_evt |=> !rd_evt && !wr_evt);

  assert_post_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mbo_valid && mbo_ready |=> host_irq && !mbo_ready);

  assert_ack_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && host_sel == 2'd1 && !(mbo_valid && mbo_ready) |=> !host_irq);

  assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mbi_valid && mbi_ready && !(wr_evt && host_sel == 2'd1) |=> !mbi_valid);

  assert_host_post_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && host_sel == 2'd1 |=> mbi_valid);

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt && !mem_rvalid |=> $stable(host_rdata));
endmodule

bind hpi_slave hpi_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel),
  .rd_evt(rd_evt), .wr_evt(wr_evt),
  .host_rdata(host_rdata), .host_irq(host_irq),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
  .mbo_valid(mbo_valid), .mbo_ready(mbo_ready),
  .mbi_valid(mbi_valid), .mbi_ready(mbi_ready));

// File: tb/tb_hpi_slave.sv
module tb_hpi_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  host_sel;
  logic        host_rd, host_wr;
  logic [15:0] host_wdata, host_rdata;
  logic        host_irq;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mbo_valid, mbo_ready, mbi_valid, mbi_ready;
  logic [15:0] mbo_data, mbi_data;

  hpi_slave dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0, stall = 0;
  logic [15:0] bmem [0:255];
  logic [15:0] exp_mem [0:255];
  logic        m_irq = 1'b0, m_mbi = 1'b0;
  logic [15:0] m_mbi_word = '0, m_ptr = '0, m_out_word = '0;

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: read data one edge after acceptance
  initial begin
    logic acc, acc_we;
    logic [7:0] acc_a;
    logic [15:0] acc_d;
    acc = 0; acc_we = 0; acc_a = 0; acc_d = 0;
    mem_ready = 1'b1; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (acc) begin
        if (acc_we) bmem[acc_a] = acc_d;
        else begin mem_rvalid = 1'b1; mem_rdata = bmem[acc_a]; end
      end
      if (mem_valid && stall > 0) begin mem_ready = 1'b0; stall--; end
      else mem_ready = 1'b1;
      acc = mem_valid && mem_ready && rst_n;
      acc_we = mem_we; acc_a = mem_addr[7:0]; acc_d = mem_wdata;
    end
  end

  // per-clock comparison of flags against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(host_irq == m_irq, "R7 irq", {15'd0, host_irq}, {15'd0, m_irq});
      chk(mbo_ready == !m_irq, "R7 mbo_ready", {15'd0, mbo_ready}, {15'd0, !m_irq});
      chk(mbi_valid == m_mbi, "R10 mbi_valid", {15'd0, mbi_valid}, {15'd0, m_mbi});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic host_op(input logic [1:0] sel, input logic wr, input logic [15:0] wd,
                         output logic [15:0] rd);
    @(negedge clk);
    host_sel = sel; host_wdata = wd;
    if (wr) host_wr = 1'b1; else host_rd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (sel == 2'd1 && !wr) m_irq = 1'b0;
    if (sel == 2'd1 && wr) begin m_mbi = 1'b1; m_mbi_word = wd; end
    repeat (11) @(negedge clk);
    rd = host_rdata;
    host_rd = 1'b0; host_wr = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic ptr_wr(input logic [15:0] a);
    logic [15:0] r;
    host_op(2'd2, 1'b1, a, r);
    m_ptr = a;
  endtask

  task automatic ptr_rd(input string req);
    logic [15:0] r;
    host_op(2'd2, 1'b0, 16'h0, r);
    chk(r == m_ptr, req, r, m_ptr);
  endtask

  task automatic data_wr(input logic [15:0] d);
    logic [15:0] r;
    host_op(2'd0, 1'b1, d, r);
    exp_mem[m_ptr[8:1]] = d;
    chk(bmem[m_ptr[8:1]] == d, "R5 memory word", bmem[m_ptr[8:1]], d);
    m_ptr = m_ptr + 16'd2;
  endtask

  task automatic data_rd();
    logic [15:0] r;
    host_op(2'd0, 1'b0, 16'h0, r);
    chk(r == exp_mem[m_ptr[8:1]], "R6 read data", r, exp_mem[m_ptr[8:1]]);
    m_ptr = m_ptr + 16'd2;
  endtask

  task automatic stat_rd();
    logic [15:0] r;
    host_op(2'd3, 1'b0, 16'h0, r);
    chk(r == {15'd0, m_irq}, "R8 status", r, {15'd0, m_irq});
  endtask

  task automatic post_out(input logic [15:0] w);
    @(negedge clk); mbo_valid = 1'b1; mbo_data = w;
    @(negedge clk); mbo_valid = 1'b0; m_irq = 1'b1; m_out_word = w;
  endtask

  task automatic take_in();
    @(negedge clk);
    chk(mbi_data == m_mbi_word, "R10 incoming word", mbi_data, m_mbi_word);
    mbi_ready = 1'b1;
    @(negedge clk); mbi_ready = 1'b0; m_mbi = 1'b0;
  endtask

  initial begin
    logic [15:0] r;
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 16'hA000 + 16'(i * 3);
      exp_mem[i] = bmem[i];
    end
    rst_n = 1'b0; host_sel = 2'd0; host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    mbo_valid = 1'b0; mbo_data = '0; mbi_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(!host_irq && mbo_ready, "R1 irq/mbo_ready", {15'd0, host_irq}, 16'h0);
    chk(!mbi_valid, "R1 mbi_valid", {15'd0, mbi_valid}, 16'h0);
    chk(!mem_valid, "R1 mem_valid", {15'd0, mem_valid}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    ptr_rd("R1 pointer after reset");
    stat_rd();

    // R2 R3 R5: burst write, one advance per held strobe, stalled request
    ptr_wr(16'h0010);
    data_wr(16'h1111);
    stall = 3;
    data_wr(16'h2222);
    data_wr(16'h3333);
    ptr_rd("R3 R4 pointer after burst");

    // R6: burst read with stall
    ptr_wr(16'h0010);
    data_rd();
    stall = 3;
    data_rd();
    data_rd();
    ptr_rd("R6 pointer after reads");

    // R4: odd pointer, bit 0 ignored for word select
    ptr_wr(16'h0011);
    data_rd();
    ptr_rd("R4 odd pointer advance");

    // R11: wrap
    ptr_wr(16'hFFFE);
    data_wr(16'h5A5A);
    ptr_rd("R11 wrap");
    ptr_wr(16'hFFFE);
    data_rd();

    // R7 R8 R9: outgoing mailbox
    post_out(16'h1234);
    stat_rd();
    @(negedge clk); mbo_valid = 1'b1; mbo_data = 16'hDEAD;
    repeat (4) @(negedge clk);
    mbo_valid = 1'b0;
    host_op(2'd1, 1'b0, 16'h0, r);
    chk(r == m_out_word, "R9 mailbox word kept under back-pressure", r, m_out_word);
    stat_rd();

    // R10: incoming mailbox
    host_op(2'd1, 1'b1, 16'hBEEF, r);
    take_in();
    host_op(2'd1, 1'b1, 16'h1111, r);
    host_op(2'd1, 1'b1, 16'h2222, r);
    take_in();
    host_op(2'd1, 1'b1, 16'h3333, r);
    // host write lands on the same edge as the internal take
    @(negedge clk); host_sel = 2'd1; host_wdata = 16'h4444; host_wr = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); mbi_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); mbi_ready = 1'b0; m_mbi = 1'b1; m_mbi_word = 16'h4444;
    repeat (10) @(negedge clk); host_wr = 1'b0;
    repeat (5) @(negedge clk);
    take_in();

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule